// File: doc/BRIEF.md
# Graphics Option Register and Masked-Write Unit

This block is the CPU-facing register window of a bitmap graphics option, together with the read-modify-write path that merges new pixel data into video memory. The CPU reaches it through a byte port with a 3-bit offset, separate read and write strobes, and a registered read return. Behind the window sit four things. The first is a control byte whose bit 0 triggers a software reset of the option. The second is an indirect select that routes the shared data offset either to a 256-byte scroll map or to the mode register. The third is the scroll map itself, walked by an auto-incrementing 8-bit index. The fourth is a 16-bit write mask, loaded one byte at a time with each byte bit-reversed and the two halves crossed over.

The merge engine is a three-state machine: `MG_IDLE`, `MG_FETCH` and `MG_STORE`. In `MG_IDLE` a request latches the address, the pattern, the CPU word, the mask and the mode, and the machine goes to `MG_FETCH`. In `MG_FETCH` the old word is read from video memory, and the machine always moves on to `MG_STORE`. In `MG_STORE` the merged word is written back with a done pulse, and the machine always returns to `MG_IDLE`. In text mode the latched write mask chooses, bit by bit, between the new pattern and the old word. In vector mode the CPU data word plays that role.

Top module: `gfx_opt_unit`

## Requirements
- R1: A write to offset 0 always stores the byte. A read at offset 0 returns the last stored byte. Every read strobe gives `reg_rvalid` high in the next cycle, with `reg_rdata` valid in that same cycle.
- R2: A write to offset 0 with bit 0 set clears the indirect select, the mode register and the write mask. The written byte is still stored.
- R3: A write to offset 0 with bit 0 clear stores the byte and leaves the select, the mode and the mask unchanged.
- R4: A write to offset 3 loads the select and sets the scroll index to 0. Select bit 7 routes offset-1 writes to the scroll map at the index, and the index then increments. When bit 7 is clear and bit 6 is set, offset-1 writes load the mode register, whose bit 0 set means vector mode.
- R5: With select bit 7 set, a read at offset 1 returns the scroll-map byte at the index, and the index then increments. The index wraps from 255 to 0 on reads and on writes.
- R6: A read at any offset other than 0 and 1, or at offset 1 with select bit 7 clear, returns 0x00 and leaves the scroll index unchanged.
- R7: A write to offset 4 loads mask bits 15:8 with the data reversed (data bit 0 goes to mask bit 15). Mask bits 7:0 are kept.
- R8: A write to offset 5 loads mask bits 7:0 with the data reversed (data bit 0 goes to mask bit 7). Mask bits 15:8 are kept.
- R9: In text mode the result bit is the pattern bit where the mask bit is 0, and the old-memory bit where the mask bit is 1.
- R10: In vector mode the result bit is the pattern bit where the CPU-word bit is 0, and the old-memory bit where the CPU-word bit is 1. The mask has no effect.
- R11: A request accepted while idle gives one `vm_rd_en` cycle. The next cycle gives one `vm_wr_en` cycle with `mg_done`, and then the unit is idle again. Requests made while busy are ignored. After reset the unit is idle with no memory strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_off | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read return valid, one cycle after reg_rd |
| mg_req | input | 1 | Merge request |
| mg_addr | input | AW | Video-memory word address for the merge |
| mg_pattern | input | 16 | New pixel pattern |
| mg_cpu_word | input | 16 | CPU data word, used as the selector in vector mode |
| mg_busy | output | 1 | Merge in progress |
| mg_done | output | 1 | Merge write-back cycle |
| vm_rd_en | output | 1 | Video-memory read enable (data returned next cycle) |
| vm_wr_en | output | 1 | Video-memory write enable |
| vm_addr | output | AW | Video-memory address |
| vm_wdata | output | 16 | Merged word written back |
| vm_rdata | input | 16 | Old word from video memory |

## Verification
The merge path is driven with single-half masks, both halves together, and a mask whose upper half was reloaded. Comparing the result against all-ones and mixed old words shows whether the byte crossover and the bit reversal are right. A vector-mode merge with a live non-zero mask and a half-set CPU word tells the two selector sources apart. The software-reset byte and a plain control byte are each followed by a merge and reads: the first must clear the state and the second must keep it. The scroll map is filled, read back, read across the 255-to-0 wrap, and read with a zero-returning read in between, which shows that the index moves only on real map accesses. A request held for three cycles must produce exactly one write-back.

// File: rtl/gfx_opt_pkg.sv
package gfx_opt_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int OFF_W  = 3;

    localparam logic [OFF_W-1:0] OFF_CTRL    = 3'd0;
    localparam logic [OFF_W-1:0] OFF_DATA    = 3'd1;
    localparam logic [OFF_W-1:0] OFF_SEL     = 3'd3;
    localparam logic [OFF_W-1:0] OFF_MASK_HI = 3'd4;
    localparam logic [OFF_W-1:0] OFF_MASK_LO = 3'd5;

    typedef enum logic [1:0] {
        MG_IDLE  = 2'd0,
        MG_FETCH = 2'd1,
        MG_STORE = 2'd2
    } mg_state_e;

    typedef enum logic [1:0] {
        RS_ZERO = 2'd0,
        RS_CTRL = 2'd1,
        RS_MAP  = 2'd2
    } rd_src_e;

    function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/gfx_opt_regs.sv
module gfx_opt_regs
    import gfx_opt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [OFF_W-1:0]   reg_off,
    input  logic [BYTE_W-1:0]  reg_wdata,
    output logic               map_wr,
    output logic               map_rd,
    output logic               idx_clr,
    output logic [1:0]         sel_q,
    output logic               mode_vec,
    output logic [WORD_W-1:0]  mask_q,
    output logic [BYTE_W-1:0]  ctrl_q,
    output logic [BYTE_W-1:0]  ctrl_hold,
    output rd_src_e            rd_src,
    output logic               rd_valid
);

    localparam int HALF = WORD_W / 2;

    logic hit_data;
    logic sw_reset;

    assign hit_data = (reg_off == OFF_DATA);
    assign sw_reset = reg_wr && (reg_off == OFF_CTRL) && reg_wdata[0];
    assign map_wr   = reg_wr && hit_data && sel_q[1];
    assign map_rd   = reg_rd && hit_data && sel_q[1];
    assign idx_clr  = reg_wr && (reg_off == OFF_SEL);

    // write side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            sel_q    <= '0;
            mode_vec <= 1'b0;
            mask_q   <= '0;
        end else if (reg_wr) begin
            unique case (reg_off)
                OFF_CTRL: begin
                    ctrl_q <= reg_wdata;
                    if (sw_reset) begin
                        sel_q    <= '0;
                        mode_vec <= 1'b0;
                        mask_q   <= '0;
                    end
                end
                OFF_SEL: begin
                    sel_q <= {reg_wdata[7], reg_wdata[6]};
                end
                OFF_DATA: begin
                    if (!sel_q[1] && sel_q[0]) begin
                        mode_vec <= reg_wdata[0];
                    end
                end
                OFF_MASK_HI: begin
                    mask_q[WORD_W-1:HALF] <= rev_byte(reg_wdata);
                end
                OFF_MASK_LO: begin
                    mask_q[HALF-1:0] <= rev_byte(reg_wdata);
                end
                default: begin
                end
            endcase
        end
    end

    // read side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_src    <= RS_ZERO;
            ctrl_hold <= '0;
        end else begin
            rd_valid <= reg_rd;
            if (reg_rd) begin
                ctrl_hold <= ctrl_q;
                if (reg_off == OFF_CTRL) begin
                    rd_src <= RS_CTRL;
                end else if (map_rd) begin
                    rd_src <= RS_MAP;
                end else begin
                    rd_src <= RS_ZERO;
                end
            end
        end
    end

endmodule

// File: rtl/gfx_opt_scroll.sv
module gfx_opt_scroll #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_clr,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q,
    output logic [IDX_W-1:0]  idx_q
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx_nxt;

    assign idx_nxt = idx_q + 1'b1;   // wraps naturally at DEPTH

    always_ff @(posedge clk) begin
        if (acc_wr) begin
            mem[idx_q] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            rdata_q <= '0;
        end else if (idx_clr) begin
            idx_q <= '0;
        end else if (acc_rd) begin
            rdata_q <= mem[idx_q];
            idx_q   <= idx_nxt;
        end else if (acc_wr) begin
            idx_q <= idx_nxt;
        end
    end

endmodule

// File: rtl/gfx_opt_merge.sv
module gfx_opt_merge
    import gfx_opt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mg_req,
    input  logic [AW-1:0]     mg_addr,
    input  logic [WORD_W-1:0] mg_pattern,
    input  logic [WORD_W-1:0] mg_cpu_word,
    input  logic [WORD_W-1:0] mask_q,
    input  logic              mode_vec,
    output logic              mg_busy,
    output logic              mg_done,
    output logic              vm_rd_en,
    output logic              vm_wr_en,
    output logic [AW-1:0]     vm_addr,
    output logic [WORD_W-1:0] vm_wdata,
    input  logic [WORD_W-1:0] vm_rdata
);

    mg_state_e         state_q, state_d;
    logic [AW-1:0]     addr_q;
    logic [WORD_W-1:0] pat_q;
    logic [WORD_W-1:0] keep_q;   // 1 = keep old bit
    logic [WORD_W-1:0] merged;
    logic              accept;

    assign accept = (state_q == MG_IDLE) && mg_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            pat_q  <= '0;
            keep_q <= '0;
        end else if (accept) begin
            addr_q <= mg_addr;
            pat_q  <= mg_pattern;
            keep_q <= mode_vec ? mg_cpu_word : mask_q;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MG_IDLE:  if (mg_req) state_d = MG_FETCH;
            MG_FETCH: state_d = MG_STORE;
            MG_STORE: state_d = MG_IDLE;
            default:  state_d = MG_IDLE;
        endcase
    end

    // per-bit merge
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        assign merged[b] = keep_q[b] ? vm_rdata[b] : pat_q[b];
    end

    // outputs
    always_comb begin
        mg_busy  = 1'b1;
        mg_done  = 1'b0;
        vm_rd_en = 1'b0;
        vm_wr_en = 1'b0;
        vm_addr  = addr_q;
        vm_wdata = merged;
        unique case (state_q)
            MG_IDLE:  mg_busy = 1'b0;
            MG_FETCH: vm_rd_en = 1'b1;
            MG_STORE: begin
                vm_wr_en = 1'b1;
                mg_done  = 1'b1;
            end
            default:  mg_busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/gfx_opt_unit.sv
module gfx_opt_unit
    import gfx_opt_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_off,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              reg_rvalid,
    input  logic              mg_req,
    input  logic [AW-1:0]     mg_addr,
    input  logic [15:0]       mg_pattern,
    input  logic [15:0]       mg_cpu_word,
    output logic              mg_busy,
    output logic              mg_done,
    output logic              vm_rd_en,
    output logic              vm_wr_en,
    output logic [AW-1:0]     vm_addr,
    output logic [15:0]       vm_wdata,
    input  logic [15:0]       vm_rdata
);

    logic              map_wr, map_rd, idx_clr;
    logic [1:0]        sel_q;
    logic              mode_vec;
    logic [WORD_W-1:0] mask_q;
    logic [BYTE_W-1:0] ctrl_q, ctrl_hold, map_q;
    logic [IDX_W-1:0]  scroll_idx;
    rd_src_e           rd_src;

    gfx_opt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .map_wr    (map_wr),
        .map_rd    (map_rd),
        .idx_clr   (idx_clr),
        .sel_q     (sel_q),
        .mode_vec  (mode_vec),
        .mask_q    (mask_q),
        .ctrl_q    (ctrl_q),
        .ctrl_hold (ctrl_hold),
        .rd_src    (rd_src),
        .rd_valid  (reg_rvalid)
    );

    gfx_opt_scroll #(.IDX_W(IDX_W), .DATA_W(BYTE_W)) u_scroll (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_clr (idx_clr),
        .acc_wr  (map_wr),
        .acc_rd  (map_rd),
        .wdata   (reg_wdata),
        .rdata_q (map_q),
        .idx_q   (scroll_idx)
    );

    gfx_opt_merge #(.AW(AW)) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .mg_req      (mg_req),
        .mg_addr     (mg_addr),
        .mg_pattern  (mg_pattern),
        .mg_cpu_word (mg_cpu_word),
        .mask_q      (mask_q),
        .mode_vec    (mode_vec),
        .mg_busy     (mg_busy),
        .mg_done     (mg_done),
        .vm_rd_en    (vm_rd_en),
        .vm_wr_en    (vm_wr_en),
        .vm_addr     (vm_addr),
        .vm_wdata    (vm_wdata),
        .vm_rdata    (vm_rdata)
    );

    always_comb begin
        unique case (rd_src)
            RS_CTRL: reg_rdata = ctrl_hold;
            RS_MAP:  reg_rdata = map_q;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gfx_opt_unit_chk.sv
module gfx_opt_unit_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [2:0]       reg_off,
    input logic [7:0]       reg_wdata,
    input logic             reg_rvalid,
    input logic [1:0]       sel_q,
    input logic             mode_vec,
    input logic [15:0]      mask_q,
    input logic [7:0]       ctrl_q,
    input logic [IDX_W-1:0] scroll_idx,
    input logic             mg_req,
    input logic             mg_busy,
    input logic             vm_rd_en,
    input logic             vm_wr_en
);

    p_ctrl_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == 3'd0) |=> (ctrl_q == $past(reg_wdata)));

    p_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    p_swreset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == 3'd0 && reg_wdata[0])
        |=> (sel_q == 2'b00 && !mode_vec && mask_q == 16'h0000));

    p_plain_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == 3'd0 && !reg_wdata[0])
        |=> ($stable(mask_q) && $stable(sel_q) && $stable(mode_vec)));

    p_idx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == 3'd3) |=> (scroll_idx == '0));

    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rd ^ reg_wr) && reg_off == 3'd1 && sel_q[1])
        |=> (scroll_idx == IDX_W'($past(scroll_idx) + 1'b1)));

    p_no_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && (reg_off != 3'd1 || !sel_q[1])) |=> $stable(scroll_idx));

    p_mask_hi_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == 3'd4) |=> $stable(mask_q[7:0]));

    p_mask_lo_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_off == 3'd5) |=> $stable(mask_q[15:8]));

    p_fetch_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mg_busy && mg_req) |=> (vm_rd_en && !vm_wr_en));

    p_store_after_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vm_wr_en |-> $past(vm_rd_en));

    p_idle_after_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vm_wr_en |=> !mg_busy);

    p_strobes_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vm_rd_en, vm_wr_en}));

endmodule

bind gfx_opt_unit gfx_opt_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_off    (reg_off),
    .reg_wdata  (reg_wdata),
    .reg_rvalid (reg_rvalid),
    .sel_q      (sel_q),
    .mode_vec   (mode_vec),
    .mask_q     (mask_q),
    .ctrl_q     (ctrl_q),
    .scroll_idx (scroll_idx),
    .mg_req     (mg_req),
    .mg_busy    (mg_busy),
    .vm_rd_en   (vm_rd_en),
    .vm_wr_en   (vm_wr_en)
);

// File: tb/sim_gfx_opt_unit.sv
module sim_gfx_opt_unit;

    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_off = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        reg_rvalid;
    logic        mg_req = 1'b0;
    logic [AW-1:0] mg_addr = '0;
    logic [15:0] mg_pattern = '0, mg_cpu_word = '0;
    logic        mg_busy, mg_done, vm_rd_en, vm_wr_en;
    logic [AW-1:0] vm_addr;
    logic [15:0] vm_wdata;
    logic [15:0] vm_rdata = '0;

    logic [15:0] vmem [16];
    logic [7:0]  smap [256];
    logic [15:0] b_mask = '0;
    logic        b_vec = 1'b0;

    int checks = 0, failures = 0;

    logic [7:0]  exp_rd_q [$];
    string       tag_rd_q [$];
    logic [15:0] exp_wr_q [$];
    logic [3:0]  exp_wa_q [$];
    string       tag_wr_q [$];

    always #5 clk = ~clk;

    gfx_opt_unit #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .mg_req(mg_req), .mg_addr(mg_addr), .mg_pattern(mg_pattern),
        .mg_cpu_word(mg_cpu_word), .mg_busy(mg_busy), .mg_done(mg_done),
        .vm_rd_en(vm_rd_en), .vm_wr_en(vm_wr_en), .vm_addr(vm_addr),
        .vm_wdata(vm_wdata), .vm_rdata(vm_rdata)
    );

    // video memory model: one-cycle read latency
    always @(posedge clk) begin
        if (vm_rd_en) vm_rdata <= vmem[vm_addr[3:0]];
        if (vm_wr_en) vmem[vm_addr[3:0]] <= vm_wdata;
    end

    function automatic logic [7:0] rv(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [15:0] exp_merge(input logic vec, input logic [15:0] pat,
                                              input logic [15:0] cpu, input logic [15:0] msk,
                                              input logic [15:0] old);
        logic [15:0] keep;
        keep = vec ? cpu : msk;
        return (pat & ~keep) | (old & keep);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] off, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_off = off; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] off, input logic [7:0] exp, input string tag);
        exp_rd_q.push_back(exp);
        tag_rd_q.push_back(tag);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_off = off;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic merge(input logic [3:0] a, input logic [15:0] pat,
                         input logic [15:0] cpu, input int hold, input string tag);
        exp_wr_q.push_back(exp_merge(b_vec, pat, cpu, b_mask, vmem[a]));
        exp_wa_q.push_back(a);
        tag_wr_q.push_back(tag);
        @(posedge clk); #1;
        mg_req = 1'b1; mg_addr = AW'(a); mg_pattern = pat; mg_cpu_word = cpu;
        for (int k = 0; k < hold; k++) @(posedge clk);
        #1 mg_req = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    // monitor: pops expected items as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && reg_rvalid) begin
                if (exp_rd_q.size() == 0) begin
                    check(1'b0, "R1 unexpected read return", {8'h0, reg_rdata}, 16'h0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_rd_q.pop_front();
                    t = tag_rd_q.pop_front();
                    check(reg_rdata == e, t, {8'h0, reg_rdata}, {8'h0, e});
                end
            end
            if (rst_n && vm_wr_en) begin
                if (exp_wr_q.size() == 0) begin
                    check(1'b0, "R11 unexpected write-back", vm_wdata, 16'h0);
                end else begin
                    logic [15:0] e;
                    logic [3:0] ea;
                    string t;
                    e = exp_wr_q.pop_front();
                    ea = exp_wa_q.pop_front();
                    t = tag_wr_q.pop_front();
                    check(vm_wdata == e, t, vm_wdata, e);
                    check(vm_addr[3:0] == ea && mg_done, "R11 write address/done",
                          {11'h0, mg_done, vm_addr[3:0]}, {11'h0, 1'b1, ea});
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vmem[0] = 16'h0000;
        vmem[1] = 16'hFFFF; vmem[2] = 16'hFFFF; vmem[3] = 16'hA5A5;
        vmem[4] = 16'hFFFF; vmem[5] = 16'h5555; vmem[6] = 16'hFFFF;
        for (int i = 7; i < 16; i++) vmem[i] = 16'hC3C3;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!mg_busy && !vm_rd_en && !vm_wr_en && !reg_rvalid, "R11 reset idle",
              {12'h0, mg_busy, vm_rd_en, vm_wr_en, reg_rvalid}, 16'h0);

        rd_reg(3'd0, 8'h00, "R1 reset control byte");
        wr_reg(3'd0, 8'h5A);
        rd_reg(3'd0, 8'h5A, "R1 control readback");
        rd_reg(3'd2, 8'h00, "R6 offset 2 read");
        rd_reg(3'd7, 8'h00, "R6 offset 7 read");

        // text mode, mask defaults to zero -> pattern passes
        merge(4'd0, 16'hBEEF, 16'h0000, 1, "R9 text mode zero mask");

        wr_reg(3'd4, 8'h01); b_mask = {rv(8'h01), b_mask[7:0]};
        merge(4'd1, 16'h0000, 16'h0000, 1, "R7 upper mask byte reversed");
        wr_reg(3'd5, 8'h03); b_mask = {b_mask[15:8], rv(8'h03)};
        merge(4'd2, 16'h1234, 16'h0000, 1, "R8 lower mask byte reversed");
        wr_reg(3'd4, 8'hF0); b_mask = {rv(8'hF0), b_mask[7:0]};
        merge(4'd3, 16'h0000, 16'hFFFF, 1, "R7 lower byte kept, R9 text merge");

        wr_reg(3'd0, 8'h02);   // bit 0 clear
        merge(4'd4, 16'h0000, 16'h0000, 1, "R3 mask kept after plain control write");
        rd_reg(3'd0, 8'h02, "R3 control byte stored");

        // vector mode via mode register
        wr_reg(3'd3, 8'h40);
        wr_reg(3'd1, 8'h01); b_vec = 1'b1;
        merge(4'd5, 16'hAAAA, 16'h00FF, 1, "R4 R10 vector merge");

        // software reset
        wr_reg(3'd0, 8'h03); b_vec = 1'b0; b_mask = '0;
        merge(4'd6, 16'h1357, 16'hFFFF, 1, "R2 reset clears mask and mode");
        rd_reg(3'd1, 8'h00, "R2 R6 select cleared");
        rd_reg(3'd0, 8'h03, "R2 control byte stored");

        // scroll map fill
        wr_reg(3'd3, 8'h80);
        for (int i = 0; i < 256; i++) begin
            smap[i] = 8'((i * 7 + 3) & 8'hFF);
            wr_reg(3'd1, smap[i]);
        end
        wr_reg(3'd3, 8'h80);
        for (int i = 0; i < 3; i++) rd_reg(3'd1, smap[i], "R5 scroll read");
        rd_reg(3'd2, 8'h00, "R6 read without index move");
        rd_reg(3'd1, smap[3], "R6 index unchanged by other read");

        wr_reg(3'd3, 8'h80);
        for (int i = 0; i < 256; i++) rd_reg(3'd1, smap[i], "R5 scroll sweep");
        rd_reg(3'd1, smap[0], "R5 read index wrap");

        // write-side wrap: index is at 1 now; restart, write 256 more -> wraps
        wr_reg(3'd3, 8'h80);
        for (int i = 0; i < 256; i++) wr_reg(3'd1, smap[i]);
        wr_reg(3'd1, 8'hEE);   // lands at index 0 after wrap
        wr_reg(3'd3, 8'h80);
        rd_reg(3'd1, 8'hEE, "R4 R5 write index wrap");
        rd_reg(3'd1, smap[1], "R4 scroll write kept neighbour");

        // held request accepted once
        merge(4'd7, 16'h0F0F, 16'h0000, 3, "R11 single write for held request");

        repeat (10) @(posedge clk);
        #1;
        check(exp_rd_q.size() == 0, "R1 all reads returned", 16'(exp_rd_q.size()), 16'h0);
        check(exp_wr_q.size() == 0, "R11 all merges written", 16'(exp_wr_q.size()), 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule